// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is the host-side engine for a serial EEPROM organised as 64 words of 16 bits and reached over three wires. The wires are a chip select, a serial clock and a data line toward the memory, plus one data line back from it. A client issues one command at a time through a valid/ready handshake. Each command carries an operation, a 6-bit word address and 16 bits of write data. The controller then builds the serial frame and clocks it out at a rate set by a parameter. On a read it returns the captured word together with a one-cycle completion pulse.

Program operations are single-word write, single-word erase, whole-array erase and whole-array write. After each of these the controller drops chip select for a minimum gap and raises it again to watch the memory's ready/busy level. It finishes when the memory reports ready, or it flags an error once a polling budget runs out. The serial clock half period, the chip-select low gap and the polling budget are parameters counted in system clocks.

Top module: `mw_host_ctrl`

## Requirements
- R1: While reset is asserted and after its release, chip select and serial clock are low, `rsp_done` is low and `cmd_ready` is high.
- R2: While chip select is high, every serial clock low phase and high phase lasts exactly `SCK_HALF` system clocks, and the frame begins with the clock low.
- R3: Each frame shifts a 1 start bit, a 2-bit opcode and a 6-bit address, most significant bit first. The data line changes only while the serial clock is low and is held stable while it is high. The command codes on `cmd_op` are 0 read (opcode 10), 1 write (01) and 2 erase (11).
- R4: Command codes 3 erase-all, 4 write-all, 5 program-enable and 6 program-disable send opcode 00 with address bits [5:4] of 10, 01, 11 and 00 respectively and zeros in [3:0].
- R5: A read (code 0) runs 26 serial clocks. The bit sampled on rising edge 10 is discarded, and the bits sampled on rising edges 11 to 26 form `rsp_rdata`, most significant bit first.
- R6: Write and write-all append the 16 bits of `cmd_wdata`, most significant first, for 25 serial clocks in total.
- R7: Chip select falls together with the last falling clock edge of a frame. It then stays low for at least `CS_GAP` system clocks before it rises again for any reason.
- R8: After a program command the controller raises chip select with the serial clock held low. It completes only after the return line reads 1, which means ready (0 means busy).
- R9: If ready has not appeared within `POLL_LIMIT` system clocks of polling, the command completes with `rsp_err` high.
- R10: `cmd_ready` is high only when no command is in flight. `rsp_done` is a single-cycle pulse, with `rsp_rdata` and `rsp_err` valid in the same cycle.
- R11: Read, program-enable and program-disable complete without a status poll. `rsp_rdata` is zero for every command except read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Controller idle, command accepted when valid |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | 6 | Word address |
| cmd_wdata | input | 16 | Write data |
| rsp_done | output | 1 | Single-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_done |
| rsp_err | output | 1 | Status poll timed out, valid with rsp_done |
| ee_cs | output | 1 | Chip select to the memory |
| ee_sck | output | 1 | Serial clock to the memory |
| ee_di | output | 1 | Serial data to the memory |
| ee_do | input | 1 | Serial data and ready/busy from the memory |

## Verification
The bench runs against a behavioural memory model that decodes frames and refuses programming while disabled. Any wrong opcode, special-command address pattern or start bit therefore shows up as a wrong word on a later read. A controller that fails to drop the dummy bit returns every word shifted right by one, and the 16'h8000 and 16'h0001 patterns make that visible. Completion times separate polled from unpolled commands: a controller that skips the poll finishes a real program operation before the model's busy time expires. A memory that never becomes ready checks the timeout flag, followed by a clean read to show recovery. Monitors measure every clock phase and every chip-select low gap, so an off-by-one divider or a gap that is too short is reported.

// File: rtl/mw_pkg.sv
package mw_pkg;

  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 16;
  localparam int HDR_W   = 1 + 2 + ADDR_W;
  localparam int FRAME_W = HDR_W + DATA_W;
  localparam int CLK_CNT_W = 5;

  typedef enum logic [2:0] {
    CMD_READ      = 3'd0,
    CMD_WRITE     = 3'd1,
    CMD_ERASE     = 3'd2,
    CMD_ERASE_ALL = 3'd3,
    CMD_WRITE_ALL = 3'd4,
    CMD_WR_EN     = 3'd5,
    CMD_WR_DIS    = 3'd6
  } mw_cmd_e;

  // opcode sent after the start bit
  function automatic logic [1:0] op_bits(input logic [2:0] c);
    case (c)
      CMD_READ:  op_bits = 2'b10;
      CMD_WRITE: op_bits = 2'b01;
      CMD_ERASE: op_bits = 2'b11;
      default:   op_bits = 2'b00;
    endcase
  endfunction

  // address field; the special commands encode themselves in the top two bits
  function automatic logic [ADDR_W-1:0] addr_bits(input logic [2:0] c,
                                                  input logic [ADDR_W-1:0] a);
    case (c)
      CMD_READ, CMD_WRITE, CMD_ERASE: addr_bits = a;
      CMD_ERASE_ALL: addr_bits = {2'b10, {(ADDR_W-2){1'b0}}};
      CMD_WRITE_ALL: addr_bits = {2'b01, {(ADDR_W-2){1'b0}}};
      CMD_WR_EN:     addr_bits = {2'b11, {(ADDR_W-2){1'b0}}};
      default:       addr_bits = {2'b00, {(ADDR_W-2){1'b0}}};
    endcase
  endfunction

  function automatic logic carries_data(input logic [2:0] c);
    carries_data = (c == CMD_WRITE) || (c == CMD_WRITE_ALL);
  endfunction

  function automatic logic is_program(input logic [2:0] c);
    is_program = (c == CMD_WRITE) || (c == CMD_ERASE) ||
                 (c == CMD_ERASE_ALL) || (c == CMD_WRITE_ALL);
  endfunction

  function automatic logic [FRAME_W-1:0] frame_bits(input logic [2:0] c,
                                                    input logic [ADDR_W-1:0] a,
                                                    input logic [DATA_W-1:0] d);
    frame_bits = {1'b1, op_bits(c), addr_bits(c, a),
                  carries_data(c) ? d : {DATA_W{1'b0}}};
  endfunction

  // serial clocks per frame: read adds one skipped bit plus the word
  function automatic logic [CLK_CNT_W-1:0] clocks_of(input logic [2:0] c);
    if (c == CMD_READ)      clocks_of = CLK_CNT_W'(HDR_W + 1 + DATA_W);
    else if (carries_data(c)) clocks_of = CLK_CNT_W'(FRAME_W);
    else                    clocks_of = CLK_CNT_W'(HDR_W);
  endfunction

endpackage

// File: rtl/mw_sck_tick.sv
module mw_sck_tick #(
  parameter int HALF = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int W = (HALF < 2) ? 1 : $clog2(HALF + 1);

  logic [W-1:0] cnt;

  assign tick = en && (cnt == W'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!en)    cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/mw_span_timer.sv
module mw_span_timer #(
  parameter int LIMIT = 25
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             en,
  output logic [$clog2(LIMIT + 1)-1:0]     count,
  output logic                             hit
);
  localparam int W = $clog2(LIMIT + 1);

  assign hit = en && (count == W'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (!en)  count <= '0;
    else if (!hit) count <= count + W'(1);
  end
endmodule

// File: rtl/mw_bit_engine.sv
module mw_bit_engine
  import mw_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [FRAME_W-1:0]    frame,
  input  logic [CLK_CNT_W-1:0]  nclk,
  input  logic                  tick,
  input  logic                  sdi,
  output logic                  active,
  output logic                  sclk,
  output logic                  sdo,
  output logic                  last_fall,
  output logic [DATA_W-1:0]     rdata
);
  localparam logic [CLK_CNT_W-1:0] FIRST_KEEP = CLK_CNT_W'(HDR_W + 1);

  logic [FRAME_W-1:0]   sreg;
  logic [CLK_CNT_W-1:0] cnt;
  logic [CLK_CNT_W-1:0] nclk_q;

  assign sdo       = active && sreg[FRAME_W-1];
  assign last_fall = active && tick && sclk && (cnt == nclk_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      sclk   <= 1'b0;
      sreg   <= '0;
      cnt    <= '0;
      nclk_q <= '0;
      rdata  <= '0;
    end else if (start) begin
      active <= 1'b1;
      sclk   <= 1'b0;
      sreg   <= frame;
      cnt    <= '0;
      nclk_q <= nclk;
      rdata  <= '0;
    end else if (active && tick) begin
      if (!sclk) begin
        sclk <= 1'b1;
        cnt  <= cnt + CLK_CNT_W'(1);
        // rising edge number cnt+1; edge HDR_W+1 carries the dummy bit
        if (cnt >= FIRST_KEEP) rdata <= {rdata[DATA_W-2:0], sdi};
      end else begin
        sclk <= 1'b0;
        sreg <= {sreg[FRAME_W-2:0], 1'b0};
        if (cnt == nclk_q) active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mw_host_ctrl.sv
module mw_host_ctrl
  import mw_pkg::*;
#(
  parameter int SCK_HALF   = 25,
  parameter int CS_GAP     = 25,
  parameter int POLL_LIMIT = 1000000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [2:0]  cmd_op,
  input  logic [5:0]  cmd_addr,
  input  logic [15:0] cmd_wdata,
  output logic        rsp_done,
  output logic [15:0] rsp_rdata,
  output logic        rsp_err,
  output logic        ee_cs,
  output logic        ee_sck,
  output logic        ee_di,
  input  logic        ee_do
);
  localparam int GAP_W  = $clog2(CS_GAP + 1);
  localparam int POLL_W = $clog2(POLL_LIMIT + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_SHIFT, ST_GAP, ST_POLL, ST_FIN} st_e;

  st_e         state;
  logic [2:0]  cmd_q;
  logic        polled_q;
  logic        err_q;

  // named events for the checker
  logic accept_w, frame_end_w, gap_done_w, poll_w, status_ok_w, timeout_w;

  logic              tick, eng_active;
  logic [DATA_W-1:0] eng_rdata;
  logic [GAP_W-1:0]  gap_cnt;
  logic [POLL_W-1:0] poll_cnt;
  logic              poll_hit;

  assign accept_w = cmd_valid && (state == ST_IDLE);
  assign poll_w   = (state == ST_POLL);

  mw_sck_tick #(.HALF(SCK_HALF)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(eng_active), .tick(tick)
  );

  mw_bit_engine u_eng (
    .clk(clk), .rst_n(rst_n),
    .start(accept_w),
    .frame(frame_bits(cmd_op, cmd_addr, cmd_wdata)),
    .nclk(clocks_of(cmd_op)),
    .tick(tick), .sdi(ee_do),
    .active(eng_active), .sclk(ee_sck), .sdo(ee_di),
    .last_fall(frame_end_w), .rdata(eng_rdata)
  );

  mw_span_timer #(.LIMIT(CS_GAP)) u_gap (
    .clk(clk), .rst_n(rst_n), .en(state == ST_GAP),
    .count(gap_cnt), .hit(gap_done_w)
  );

  mw_span_timer #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk(clk), .rst_n(rst_n), .en(poll_w),
    .count(poll_cnt), .hit(poll_hit)
  );

  // status is trusted once chip select has been high for a half period
  assign status_ok_w = poll_w && (poll_cnt >= POLL_W'(SCK_HALF)) && ee_do;
  assign timeout_w   = poll_w && poll_hit && !status_ok_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cmd_q    <= 3'd0;
      polled_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept_w) begin
          state    <= ST_SHIFT;
          cmd_q    <= cmd_op;
          polled_q <= 1'b0;
          err_q    <= 1'b0;
        end
        ST_SHIFT: if (frame_end_w) state <= ST_GAP;
        ST_GAP: if (gap_done_w)
          state <= (is_program(cmd_q) && !polled_q) ? ST_POLL : ST_FIN;
        ST_POLL: begin
          if (status_ok_w) begin
            state    <= ST_GAP;
            polled_q <= 1'b1;
          end else if (timeout_w) begin
            state    <= ST_GAP;
            polled_q <= 1'b1;
            err_q    <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state == ST_IDLE);
  assign ee_cs     = (state == ST_SHIFT) || poll_w;
  assign rsp_done  = (state == ST_FIN);
  assign rsp_err   = rsp_done && err_q;
  assign rsp_rdata = (rsp_done && cmd_q == CMD_READ) ? eng_rdata : '0;

endmodule

// File: rtl/mw_host_chk.sv
module mw_host_chk #(
  parameter int SCK_HALF = 25,
  parameter int CS_GAP   = 25
) (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic sck,
  input logic di,
  input logic cmd_ready,
  input logic rsp_done,
  input logic poll_w,
  input logic frame_end_w
);
  localparam int CW = $clog2(SCK_HALF + CS_GAP + 2) + 1;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] hi_len, lo_len, cs_lo_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_len    <= '0;
      lo_len    <= '0;
      cs_lo_len <= CMAX;
    end else begin
      hi_len    <= (cs && sck)  ? ((hi_len == CMAX) ? CMAX : hi_len + CW'(1)) : '0;
      lo_len    <= (cs && !sck) ? ((lo_len == CMAX) ? CMAX : lo_len + CW'(1)) : '0;
      cs_lo_len <= !cs ? ((cs_lo_len == CMAX) ? CMAX : cs_lo_len + CW'(1)) : '0;
    end
  end

  AST_SCK_HIGH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck) |-> hi_len == CW'(SCK_HALF)); // R2
  AST_SCK_LOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> lo_len == CW'(SCK_HALF)); // R2
  AST_DI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(di)); // R3
  AST_CS_DROP_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_w |=> !cs); // R7
  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs) |-> cs_lo_len >= CW'(CS_GAP)); // R7
  AST_POLL_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    poll_w |-> (cs && !sck)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R10
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!cs && !sck)); // R10
endmodule

bind mw_host_ctrl mw_host_chk #(.SCK_HALF(SCK_HALF), .CS_GAP(CS_GAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(ee_cs), .sck(ee_sck), .di(ee_di),
  .cmd_ready(cmd_ready), .rsp_done(rsp_done), .poll_w(poll_w),
  .frame_end_w(frame_end_w)
);

// File: tb/tb_mw_host_ctrl.sv
module tb_mw_host_ctrl;
  localparam int HALF  = 3;
  localparam int GAP   = 5;
  localparam int PLIM  = 3000;
  localparam int BUSY  = 400;

  localparam logic [2:0] OP_RD = 3'd0, OP_WR = 3'd1, OP_ER = 3'd2, OP_ERAL = 3'd3,
                         OP_WRAL = 3'd4, OP_EN = 3'd5, OP_DIS = 3'd6;

  // {op, addr, wdata, expected rdata, expects a busy wait}
  localparam int NV = 19;
  localparam logic [41:0] VEC [NV] = '{
    {OP_EN,   6'd0,  16'h0000, 16'h0000, 1'b0},
    {OP_WR,   6'd5,  16'hA5C3, 16'h0000, 1'b1},
    {OP_RD,   6'd5,  16'h0000, 16'hA5C3, 1'b0},
    {OP_ER,   6'd5,  16'h0000, 16'h0000, 1'b1},
    {OP_RD,   6'd5,  16'h0000, 16'hFFFF, 1'b0},
    {OP_WRAL, 6'd0,  16'h1234, 16'h0000, 1'b1},
    {OP_RD,   6'd63, 16'h0000, 16'h1234, 1'b0},
    {OP_DIS,  6'd0,  16'h0000, 16'h0000, 1'b0},
    {OP_WR,   6'd0,  16'hBEEF, 16'h0000, 1'b0},
    {OP_RD,   6'd0,  16'h0000, 16'h1234, 1'b0},
    {OP_ERAL, 6'd0,  16'h0000, 16'h0000, 1'b0},
    {OP_RD,   6'd9,  16'h0000, 16'h1234, 1'b0},
    {OP_EN,   6'd0,  16'h0000, 16'h0000, 1'b0},
    {OP_ERAL, 6'd0,  16'h0000, 16'h0000, 1'b1},
    {OP_RD,   6'd0,  16'h0000, 16'hFFFF, 1'b0},
    {OP_WR,   6'd62, 16'h0001, 16'h0000, 1'b1},
    {OP_RD,   6'd62, 16'h0000, 16'h0001, 1'b0},
    {OP_WR,   6'd33, 16'h8000, 16'h0000, 1'b1},
    {OP_RD,   6'd33, 16'h0000, 16'h8000, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [5:0] cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic cmd_ready, rsp_done, rsp_err, ee_cs, ee_sck, ee_di, ee_do;
  logic [15:0] rsp_rdata;

  always #5 clk = ~clk;

  mw_host_ctrl #(.SCK_HALF(HALF), .CS_GAP(GAP), .POLL_LIMIT(PLIM)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .ee_cs(ee_cs), .ee_sck(ee_sck), .ee_di(ee_di), .ee_do(ee_do)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [15:0] mem [64];
  logic sck_p = 1'b0, cs_p = 1'b0, do_r = 1'b0, wen = 1'b0, stuck = 1'b0;
  int bc = 0, busy = 0;
  logic [31:0] sh = '0;
  logic [8:0] hdr = '0;

  assign ee_do = (ee_cs && bc == 0) ? (busy == 0) : do_r;

  always @(negedge clk) begin
    if (busy > 0) busy--;
    if (ee_cs && !cs_p) begin bc = 0; sh = '0; hdr = '0; end
    if (ee_cs && ee_sck && !sck_p) begin
      sh = {sh[30:0], ee_di};
      bc++;
      if (bc == 9) hdr = sh[8:0];
    end
    if (ee_cs && !ee_sck && sck_p && hdr[8] && hdr[7:6] == 2'b10 && bc >= 9 && bc <= 25)
      do_r = (bc == 9) ? 1'b0 : mem[hdr[5:0]][25 - bc];
    if (!ee_cs && cs_p && bc >= 9 && hdr[8]) begin
      case (hdr[7:6])
        2'b01: if (wen && bc == 25) begin mem[hdr[5:0]] = sh[15:0]; busy = stuck ? (1 << 30) : BUSY; end
        2'b11: if (wen) begin mem[hdr[5:0]] = 16'hFFFF; busy = stuck ? (1 << 30) : BUSY; end
        2'b00: case (hdr[5:4])
          2'b11: wen = 1'b1;
          2'b00: wen = 1'b0;
          2'b10: if (wen) begin for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF; busy = BUSY; end
          default: if (wen && bc == 25) begin
            for (int i = 0; i < 64; i++) mem[i] = sh[15:0];
            busy = BUSY;
          end
        endcase
        default: ;
      endcase
    end
    sck_p = ee_sck;
    cs_p  = ee_cs;
  end

  // ---------------- timing monitors ----------------
  int hi_run = 0, lo_run = 0, cs_lo = 1000, bad_phase = 0, bad_gap = 0, phases = 0;
  logic mon_sck = 1'b0, mon_cs = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (ee_sck != mon_sck && (mon_cs || ee_cs)) begin
        phases++;
        if ((mon_sck ? hi_run : lo_run) != HALF) bad_phase++;
      end
      if (ee_cs && !mon_cs && cs_lo < GAP) bad_gap++;
      hi_run = (ee_cs && ee_sck) ? hi_run + 1 : 0;
      lo_run = (ee_cs && !ee_sck) ? lo_run + 1 : 0;
      cs_lo  = ee_cs ? 0 : cs_lo + 1;
      mon_sck = ee_sck;
      mon_cs  = ee_cs;
    end
  end

  // ---------------- command driver ----------------
  task automatic do_cmd(input logic [2:0] op, input logic [5:0] a, input logic [15:0] d,
                        output logic [15:0] rd, output logic e, output int cyc);
    bit ready_seen = 0;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd7; cmd_wdata = 16'hDEAD;
    cyc = 1;
    while (!rsp_done && cyc < 20000) begin
      if (cmd_ready) ready_seen = 1;
      @(negedge clk);
      cyc++;
    end
    rd = rsp_rdata;
    e  = rsp_err;
    chk(rsp_done, "R10 completion pulse seen", 32'(rsp_done), 1);
    chk(!ready_seen, "R10 cmd_ready low while busy", 32'(ready_seen), 0);
    @(negedge clk);
    chk(!rsp_done, "R10 done lasts one cycle", 32'(rsp_done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog expired actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    logic e;
    int cyc;
    for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!ee_cs, "R1 cs low in reset", 32'(ee_cs), 0);
    chk(!ee_sck, "R1 sck low in reset", 32'(ee_sck), 0);
    chk(!rsp_done, "R1 done low in reset", 32'(rsp_done), 0);
    chk(cmd_ready, "R1 ready high in reset", 32'(cmd_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ee_cs && !ee_sck && cmd_ready, "R1 idle after reset",
        {29'd0, ee_cs, ee_sck, cmd_ready}, 32'd1);

    // table walk: R3 R4 R5 R6 R8 R11
    for (int v = 0; v < NV; v++) begin
      do_cmd(VEC[v][41:39], VEC[v][38:33], VEC[v][32:17], rd, e, cyc);
      chk(rd == VEC[v][16:1], $sformatf("R5 R11 vector %0d rdata", v), 32'(rd), 32'(VEC[v][16:1]));
      chk(!e, $sformatf("R9 vector %0d no error", v), 32'(e), 0);
      if (VEC[v][0])
        chk(cyc > BUSY, $sformatf("R8 vector %0d waited for ready", v), cyc, BUSY);
      else
        chk(cyc < BUSY, $sformatf("R11 vector %0d no busy wait", v), cyc, BUSY);
    end

    // R9 timeout: memory never reports ready
    stuck = 1'b1;
    do_cmd(OP_WR, 6'd7, 16'h5555, rd, e, cyc);
    chk(e, "R9 timeout flag", 32'(e), 1);
    chk(cyc >= PLIM, "R9 timeout waited full budget", cyc, PLIM);
    stuck = 1'b0;
    @(negedge clk);
    busy = 0;
    do_cmd(OP_RD, 6'd7, 16'h0, rd, e, cyc);
    chk(rd == 16'h5555 && !e, "R6 R9 read after timeout", {15'd0, e, rd}, 32'h5555);

    // R2 R3 R7 monitors
    chk(phases > 100, "R2 clock phases observed", phases, 100);
    chk(bad_phase == 0, "R2 clock phase length", bad_phase, 0);
    chk(bad_gap == 0, "R7 chip-select low gap", bad_gap, 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule